// File: doc/BRIEF.md
# Synthesizer and DAC Serial Programmer

This block loads a radio frequency synthesizer and a serial DAC through one shared serial clock and data pair. The host presents a target code, a word length and a data word, then pulses `start` for one cycle. The engine shifts the word out, most significant bit first, at half the system clock rate. A synthesizer transfer frames the word with an active-low latch enable, and the synthesizer captures the word on the rising edge of that line. A DAC transfer frames the word with an active-low DAC select instead.

Each target may only be loaded in its own radio window. The synthesizer is loaded while the radio is idle. The receive-reference DAC (RSSI / CCA threshold) is loaded as reception of a packet begins. The transmit-power DAC is loaded as transmission of a packet begins. A request made outside its window is held pending and goes out at the first clock edge at which the window opens. `busy` covers the whole transfer plus one serial clock period after the latch edge, and `done` pulses once when `busy` falls.

Top module: `syn_dac_prog`

## Requirements
- R1: After reset, and while reset is held, the outputs are: `ser_clk`=0, `ser_dat`=0, `syn_latch_n`=1, `dac_sel_n`=1, `busy`=0, `done`=0 and `pending`=0.
- R2: Let T be the launch edge. During a transfer `ser_clk` is low in the cycle after T and high in the cycle after that. It keeps this 2-cycle pattern for exactly L high phases, where L is the effective word length. `ser_clk` is low whenever `busy` is low.
- R3: Bit L-1 of `data_in` goes out first and bit 0 goes out last. Each bit is driven in the low phase of `ser_clk` and holds through the following high phase, so it is stable when `ser_clk` rises.
- R4: Target code 0 selects the synthesizer and drives `syn_latch_n` low. Code 1 selects the transmit-power DAC and code 2 selects the receive-reference DAC; both drive `dac_sel_n` low. The active line is low for the 2L cycles of shifting and rises one cycle after the last high phase of `ser_clk`. The two lines are never low together.
- R5: `radio_mode` uses these codes: 0 = idle, 1 = receive start, 2 = transmit start, 3 = other. Target 0 needs mode 0, target 2 needs mode 1, and target 1 needs mode 2. A start whose window is open in the cycle it is sampled launches at that edge.
- R6: A start sampled while its window is closed raises `pending` from that edge on. The held request launches at the first edge at which its window is open, and `pending` clears at that same edge.
- R7: `busy` is high for 2L+2 cycles starting at the launch edge. `done` is high for exactly the one cycle after `busy` falls.
- R8: A start is ignored, and leaves no effect on later outputs, if it is sampled while `busy` or `pending` is high or if it carries target code 3.
- R9: The effective length L is `word_len` clamped to the range 8 to 24. Below 8 gives 8, above 24 gives 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to program a target |
| target | input | 2 | Target code (0 synthesizer, 1 transmit-power DAC, 2 receive-reference DAC) |
| word_len | input | 5 | Requested word length in bits |
| data_in | input | 24 | Word to send, right aligned |
| radio_mode | input | 2 | Radio state code (0 idle, 1 receive start, 2 transmit start, 3 other) |
| ser_clk | output | 1 | Shared serial clock, system clock divided by 2 |
| ser_dat | output | 1 | Shared serial data |
| syn_latch_n | output | 1 | Synthesizer latch enable, low while shifting |
| dac_sel_n | output | 1 | DAC select, low while shifting |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| pending | output | 1 | A request is waiting for its radio window |

## Verification
Count cycles from the launch edge T, where c = 0 is the cycle right after T. The bench samples every cycle on the falling clock. It expects `ser_clk` equal to c mod 2 and the active select low for c < 2L. Data bit L-1-c/2 is expected for c < 2L, `busy` is expected for c ≤ 2L+1, and `done` only at c = 2L+2. A held request is timed from the edge at which its window opens, so c = 0 falls one cycle after `radio_mode` changes. `pending` is checked on the falling clock right after the sampling edge.

// File: rtl/syn_dac_pkg.sv
// Shared types for the synthesizer/DAC serial programmer.
// Assumes target and radio-mode codes are two bits wide, as the top-level ports define.
package syn_dac_pkg;

    typedef enum logic [1:0] {
        TGT_SYNTH = 2'd0,
        TGT_TXDAC = 2'd1,
        TGT_RXDAC = 2'd2,
        TGT_NONE  = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        MODE_IDLE    = 2'd0,
        MODE_RXSTART = 2'd1,
        MODE_TXSTART = 2'd2,
        MODE_OTHER   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } st_e;

    // True when the given target may be programmed in the given radio mode
    function automatic logic window_open(input tgt_e t, input mode_e m);
        case (t)
            TGT_SYNTH: window_open = (m == MODE_IDLE);
            TGT_RXDAC: window_open = (m == MODE_RXSTART);
            TGT_TXDAC: window_open = (m == MODE_TXSTART);
            default:   window_open = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/syn_dac_gate.sv
// Request gate: accepts host start requests, clamps the word length, and checks
// the target's radio window. Requests whose window is closed are held pending.
// Assumes engine_idle is high only when the shift engine can take a launch.
module syn_dac_gate
    import syn_dac_pkg::*;
#(
    parameter int MIN_BITS = 8,
    parameter int MAX_BITS = 24,
    parameter int LEN_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          target,
    input  logic [LEN_W-1:0]    word_len,
    input  logic [MAX_BITS-1:0] data_in,
    input  logic [1:0]          radio_mode,
    input  logic                engine_idle,
    output logic                launch,
    output tgt_e                launch_tgt,
    output logic [LEN_W-1:0]    launch_len,
    output logic [MAX_BITS-1:0] launch_data,
    output logic                pending
);

    localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(MIN_BITS);
    localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(MAX_BITS);

    logic                pend_q;
    tgt_e                pend_tgt;
    logic [LEN_W-1:0]    pend_len;
    logic [MAX_BITS-1:0] pend_data;

    logic             accept;
    logic             start_ok;
    logic             pend_ok;
    logic [LEN_W-1:0] len_clamped;
    tgt_e             req_tgt;
    mode_e            mode;

    // Decode the request target, the radio mode and the clamped length
    always_comb begin
        req_tgt = tgt_e'(target);
        mode    = mode_e'(radio_mode);
        if (word_len < LEN_LO)      len_clamped = LEN_LO;
        else if (word_len > LEN_HI) len_clamped = LEN_HI;
        else                        len_clamped = word_len;
    end

    // Decide whether a new or a held request launches this cycle
    always_comb begin
        accept   = start && engine_idle && !pend_q && (req_tgt != TGT_NONE);
        start_ok = accept && window_open(req_tgt, mode);
        pend_ok  = pend_q && engine_idle && window_open(pend_tgt, mode);
        launch   = start_ok || pend_ok;
        if (pend_ok) begin
            launch_tgt  = pend_tgt;
            launch_len  = pend_len;
            launch_data = pend_data;
        end else begin
            launch_tgt  = req_tgt;
            launch_len  = len_clamped;
            launch_data = data_in;
        end
    end

    // Hold a request whose window is closed until it launches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            pend_tgt  <= TGT_SYNTH;
            pend_len  <= LEN_LO;
            pend_data <= '0;
        end else if (accept && !start_ok) begin
            pend_q    <= 1'b1;
            pend_tgt  <= req_tgt;
            pend_len  <= len_clamped;
            pend_data <= data_in;
        end else if (pend_ok) begin
            pend_q <= 1'b0;
        end
    end

    assign pending = pend_q;

endmodule

// File: rtl/syn_dac_engine.sv
// Shift engine: divides the system clock by two and shifts a word out MSB
// first. After the last bit it holds busy for one more serial clock period.
// Assumes launch only arrives while idle is high and launch_len is within range.
module syn_dac_engine
    import syn_dac_pkg::*;
#(
    parameter int MAX_BITS = 24,
    parameter int LEN_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  tgt_e                launch_tgt,
    input  logic [LEN_W-1:0]    launch_len,
    input  logic [MAX_BITS-1:0] launch_data,
    output logic                sclk,
    output logic                sdat,
    output logic                shifting,
    output tgt_e                cur_tgt,
    output logic                busy,
    output logic                done,
    output logic                idle
);

    localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(MAX_BITS);

    st_e                 state;
    logic                sclk_q;
    logic [MAX_BITS-1:0] shreg;
    logic [LEN_W-1:0]    bits_left;
    logic                tail_q;
    logic                done_q;
    tgt_e                tgt_q;
    logic [LEN_W-1:0]    shamt;

    // Left-align the word so that its top bit sits at the shift-out position
    assign shamt = LEN_HI - launch_len;

    // Sequence the shift phases, the bit count and the tail period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sclk_q    <= 1'b0;
            shreg     <= '0;
            bits_left <= '0;
            tail_q    <= 1'b0;
            done_q    <= 1'b0;
            tgt_q     <= TGT_SYNTH;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (launch) begin
                        state     <= ST_SHIFT;
                        sclk_q    <= 1'b0;
                        shreg     <= launch_data << shamt;
                        bits_left <= launch_len - LEN_W'(1);
                        tgt_q     <= launch_tgt;
                    end
                end
                ST_SHIFT: begin
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                    end else begin
                        sclk_q <= 1'b0;
                        if (bits_left == '0) begin
                            state  <= ST_TAIL;
                            tail_q <= 1'b0;
                        end else begin
                            shreg     <= {shreg[MAX_BITS-2:0], 1'b0};
                            bits_left <= bits_left - LEN_W'(1);
                        end
                    end
                end
                ST_TAIL: begin
                    if (tail_q) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        tail_q <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the serial pair and the status flags from the registered state
    always_comb begin
        shifting = (state == ST_SHIFT);
        sclk     = sclk_q;
        sdat     = shifting && shreg[MAX_BITS-1];
        cur_tgt  = tgt_q;
        busy     = (state != ST_IDLE);
        idle     = (state == ST_IDLE);
        done     = done_q;
    end

endmodule

// File: rtl/syn_dac_select.sv
// Select decoder: drives the active-low synthesizer latch or the DAC select
// while a word is shifting. Assumes cur_tgt is never TGT_NONE while shifting.
module syn_dac_select
    import syn_dac_pkg::*;
(
    input  logic shifting,
    input  tgt_e cur_tgt,
    output logic latch_n,
    output logic dsel_n
);

    // Route the framing strobe to the line that belongs to the target
    always_comb begin
        latch_n = !(shifting && (cur_tgt == TGT_SYNTH));
        dsel_n  = !(shifting && ((cur_tgt == TGT_TXDAC) || (cur_tgt == TGT_RXDAC)));
    end

endmodule

// File: rtl/syn_dac_prog.sv
// Top level of the synthesizer/DAC serial programmer. It joins the request
// gate, the shift engine and the select decoder. Assumes one clock domain and
// a synchronous active-low reset.
module syn_dac_prog
    import syn_dac_pkg::*;
#(
    parameter int MIN_BITS = 8,
    parameter int MAX_BITS = 24,
    parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          target,
    input  logic [LEN_W-1:0]    word_len,
    input  logic [MAX_BITS-1:0] data_in,
    input  logic [1:0]          radio_mode,
    output logic                ser_clk,
    output logic                ser_dat,
    output logic                syn_latch_n,
    output logic                dac_sel_n,
    output logic                busy,
    output logic                done,
    output logic                pending
);

    logic                launch;
    tgt_e                launch_tgt;
    logic [LEN_W-1:0]    launch_len;
    logic [MAX_BITS-1:0] launch_data;
    logic                engine_idle;
    logic                shifting;
    tgt_e                cur_tgt;

    syn_dac_gate #(
        .MIN_BITS (MIN_BITS),
        .MAX_BITS (MAX_BITS),
        .LEN_W    (LEN_W)
    ) gate_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .target      (target),
        .word_len    (word_len),
        .data_in     (data_in),
        .radio_mode  (radio_mode),
        .engine_idle (engine_idle),
        .launch      (launch),
        .launch_tgt  (launch_tgt),
        .launch_len  (launch_len),
        .launch_data (launch_data),
        .pending     (pending)
    );

    syn_dac_engine #(
        .MAX_BITS (MAX_BITS),
        .LEN_W    (LEN_W)
    ) engine_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_tgt  (launch_tgt),
        .launch_len  (launch_len),
        .launch_data (launch_data),
        .sclk        (ser_clk),
        .sdat        (ser_dat),
        .shifting    (shifting),
        .cur_tgt     (cur_tgt),
        .busy        (busy),
        .done        (done),
        .idle        (engine_idle)
    );

    syn_dac_select select_i (
        .shifting (shifting),
        .cur_tgt  (cur_tgt),
        .latch_n  (syn_latch_n),
        .dsel_n   (dac_sel_n)
    );

endmodule

// File: rtl/syn_dac_prog_chk.sv
// Property checker for the serial programmer, bound to the top module.
// Assumes the port names of syn_dac_prog.
module syn_dac_prog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] radio_mode,
    input logic       ser_clk,
    input logic       ser_dat,
    input logic       syn_latch_n,
    input logic       dac_sel_n,
    input logic       busy,
    input logic       done,
    input logic       pending
);

    // R1: outputs are quiet in the cycle after a reset edge
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!ser_clk && !busy && !done && !pending && syn_latch_n && dac_sel_n));

    // R2: serial clock stays low outside a transfer
    assert_clk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ser_clk);

    // R3: data does not move while the serial clock rises
    assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_dat));

    // R4: the two framing lines are never active together
    assert_select_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!syn_latch_n && !dac_sel_n));

    // R5: a synthesizer transfer only opens in the idle radio mode
    assert_synth_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(syn_latch_n) |-> ($past(radio_mode) == 2'd0));

    // R5: a DAC transfer only opens in a receive-start or transmit-start mode
    assert_dac_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sel_n) |-> (($past(radio_mode) == 2'd1) || ($past(radio_mode) == 2'd2)));

    // R6: a held request never coexists with a running transfer
    assert_pending_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !busy);

    // R7: done is a single-cycle pulse that follows the fall of busy
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7: busy rises together with a framing line
    assert_busy_frames_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!syn_latch_n || !dac_sel_n));

endmodule

bind syn_dac_prog syn_dac_prog_chk chk_i (.*);

// File: tb/syn_dac_prog_tb_top.sv
`timescale 1ns/1ps
module syn_dac_prog_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  target = 2'd0;
    logic [4:0]  word_len = 5'd8;
    logic [23:0] data_in = '0;
    logic [1:0]  radio_mode = 2'd3;
    logic        ser_clk, ser_dat, syn_latch_n, dac_sel_n, busy, done, pending;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    syn_dac_prog dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .target(target),
        .word_len(word_len), .data_in(data_in), .radio_mode(radio_mode),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .syn_latch_n(syn_latch_n),
        .dac_sel_n(dac_sel_n), .busy(busy), .done(done), .pending(pending)
    );

    function automatic int eff_len(input int l);
        if (l < 8) return 8;
        if (l > 24) return 24;
        return l;
    endfunction

    function automatic logic [1:0] window_for(input logic [1:0] t);
        case (t)
            2'd0: return 2'd0;
            2'd1: return 2'd2;
            2'd2: return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [23:0] masked(input logic [23:0] d, input int l);
        return d & ((24'h1 << l) - 24'h1);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Drive a start request at a falling edge; returns after the sampling edge
    task automatic issue(input logic [1:0] t, input int l, input logic [23:0] d);
        target   = t;
        word_len = 5'(l);
        data_in  = d;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Observe one transfer; c = 0 is the cycle right after the launch edge
    task automatic observe(input logic [1:0] t, input int l, input logic [23:0] d,
                           input bit poke);
        int          err_clk = 0, err_sel = 0, err_busy = 0, err_done = 0, err_hold = 0;
        logic [23:0] cap = '0;
        logic        low_bit = 1'b0;
        logic        want_latch, want_dsel;
        for (int c = 0; c <= 2 * l + 3; c++) begin
            want_latch = !((c < 2 * l) && (t == 2'd0));
            want_dsel  = !((c < 2 * l) && (t != 2'd0));
            if (ser_clk !== ((c < 2 * l) ? 1'(c % 2) : 1'b0)) err_clk++;
            if ((syn_latch_n !== want_latch) || (dac_sel_n !== want_dsel)) err_sel++;
            if (busy !== (c <= 2 * l + 1)) err_busy++;
            if (done !== (c == 2 * l + 2)) err_done++;
            if (c < 2 * l) begin
                if (c % 2 == 0) low_bit = ser_dat;
                else begin
                    if (ser_dat !== low_bit) err_hold++;
                    cap = {cap[22:0], ser_dat};
                end
            end
            if (poke && c == 3) begin
                target = 2'd1; data_in = 24'h5A5A5A; word_len = 5'd16; start = 1'b1;
            end
            if (poke && c == 4) start = 1'b0;
            @(negedge clk);
        end
        chk("R2 serial clock pattern errors", 32'(err_clk), 32'd0);
        chk("R3 shifted word", 32'(cap), 32'(masked(d, l)));
        chk("R3 bit hold across rising edge", 32'(err_hold), 32'd0);
        chk("R4 select framing errors", 32'(err_sel), 32'd0);
        chk("R7 busy span errors", 32'(err_busy), 32'd0);
        chk("R7 done pulse errors", 32'(err_done), 32'd0);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset outputs", {25'd0, ser_clk, ser_dat, syn_latch_n, dac_sel_n, busy, done, pending},
            {25'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);

        // R5: synthesizer in idle window, full length
        radio_mode = 2'd0;
        issue(2'd0, 24, 24'hC3A581);
        observe(2'd0, 24, 24'hC3A581, 1'b0);

        // R9: length below minimum clamps to 8
        radio_mode = 2'd1;
        issue(2'd2, 3, 24'hFFFF96);
        observe(2'd2, eff_len(3), 24'hFFFF96, 1'b0);

        // R9: length above maximum clamps to 24
        radio_mode = 2'd2;
        issue(2'd1, 30, 24'h81F00F);
        observe(2'd1, eff_len(30), 24'h81F00F, 1'b0);

        // R8: start with target 3 is ignored
        radio_mode = 2'd0;
        issue(2'd3, 12, 24'h000ABC);
        repeat (3) @(negedge clk);
        chk("R8 target 3 ignored busy/pending", {30'd0, busy, pending}, 32'd0);

        // R6: request outside window waits, then a second start is ignored
        radio_mode = 2'd3;
        issue(2'd0, 10, 24'h0002B7);
        chk("R6 pending raised", 32'(pending), 32'd1);
        chk("R6 no transfer while held", {30'd0, busy, syn_latch_n}, 32'd1);
        issue(2'd1, 16, 24'h00FFFF);
        @(negedge clk);
        radio_mode = 2'd0;
        @(negedge clk);
        chk("R6 pending cleared at launch", 32'(pending), 32'd0);
        observe(2'd0, 10, 24'h0002B7, 1'b0);
        chk("R8 second start while pending dropped", {30'd0, pending, dac_sel_n}, 32'd1);

        // R8: start while busy is ignored
        radio_mode = 2'd0;
        issue(2'd0, 9, 24'h000155);
        observe(2'd0, 9, 24'h000155, 1'b1);
        radio_mode = 2'd2;
        repeat (3) @(negedge clk);
        chk("R8 start during busy dropped", {29'd0, pending, busy, dac_sel_n}, 32'd1);

        // Random transfers, sometimes through the pending path
        for (int k = 0; k < 30; k++) begin
            logic [1:0]  t = 2'($urandom % 3);
            int          l = 8 + int'($urandom % 17);
            logic [23:0] d = 24'($urandom);
            if ($urandom % 3 == 0) begin
                radio_mode = 2'd3;
                issue(t, l, d);
                repeat (int'($urandom % 4)) @(negedge clk);
                chk("R6 random held request", {30'd0, pending, busy}, 32'd2);
                radio_mode = window_for(t);
                @(negedge clk);
            end else begin
                radio_mode = window_for(t);
                issue(t, l, d);
            end
            observe(t, l, d, 1'b0);
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule